// File: doc/BRIEF.md
# Vectored External Interrupt Controller

This block sits beside a processor's trap logic and turns a set of level-sensitive interrupt lines into a trap decision. It samples a parameterised number of external lines, along with one software line and one timer line, into registers one clock after they arrive. A per-line enable register filters the sampled external lines. The result drives a single machine external-pending flag and a five-bit index of the lowest line that is both pending and enabled.

From these, and from the global interrupt enables the core supplies, the block raises a trap request. It also gives the cause code and the target address, both derived from a trap-vector base. Bit 0 of that base turns vectoring on. A one-bit mode register chooses the address an external interrupt uses under vectoring. With the mode off, all external lines share one slot. With the mode on, each line has its own slot.

Software reaches the enable, mode, pending and index registers through a small register port. That port supports write, set-bits and clear-bits operations. The pending and index registers are read-only.

Top module: `ext_irq_vectorer`

## Requirements
- R1: The number of external lines `NUM_LINES` is a parameter from 1 to 32. Each implemented line has one pending bit and one enable bit. When the enable or pending register is read, bits at or above `NUM_LINES` read as 0.
- R2: The pending register equals `irq_lines` as it was at the previous rising clock edge. `sw_irq` and `tmr_irq` are registered in the same way before they can cause a trap.
- R3: `ext_pend_flag` is 1 exactly when some line is set in both the pending register and the enable register.
- R4: `low_idx` is the lowest-numbered line that is both pending and enabled, or 0 when there is none. Reading select 3 returns it zero-extended to 32 bits.
- R5: An external interrupt is requested only when all four hold: a line is pending, that line is enabled, `glb_mie` is 1, and `en_ext` is 1.
- R6: When `vec_base[0]` is 0, `trap_addr` is `vec_base` with bits [1:0] forced to 0, for every cause.
- R7: When `vec_base[0]` is 1 and the mode bit is 0, an external interrupt gives cause 11 and address base + 0x2c.
- R8: When `vec_base[0]` is 1 and the mode bit is 1, an external interrupt gives cause 16 + `low_idx` and address base + (16 + `low_idx`) × 4.
- R9: A software interrupt (registered `sw_irq` with `en_sw`, cause 3) wins over a timer interrupt (registered `tmr_irq` with `en_tmr`, cause 7). Both win over an external interrupt in either mode. Vectoring places each at base + cause × 4.
- R10: After reset, the enable register holds ones for every implemented line and the mode bit is 0.
- R11: `csr_sel` chooses the register: 0 enable, 1 mode, 2 pending, 3 index. `csr_op` chooses the operation: 0 idle, 1 write, 2 set bits, 3 clear bits. Only the implemented enable bits and bit 0 of the mode register can change, and they change at the next clock edge.
- R12: A non-idle `csr_op` with select 2 or 3 raises `csr_fault` in the same cycle and changes nothing.
- R13: `delay_entry` forces `trap_req` to 0 in that cycle. It leaves the pending state, index, cause and address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Level-sensitive external interrupt lines |
| sw_irq | input | 1 | Software interrupt line |
| tmr_irq | input | 1 | Timer interrupt line |
| glb_mie | input | 1 | Global machine interrupt enable |
| en_ext | input | 1 | Global external interrupt enable |
| en_tmr | input | 1 | Timer interrupt enable |
| en_sw | input | 1 | Software interrupt enable |
| vec_base | input | 32 | Trap vector base; bit 0 turns vectoring on |
| delay_entry | input | 1 | Holds off the trap request this cycle |
| csr_sel | input | 2 | Register select |
| csr_op | input | 2 | Register operation |
| csr_wdata | input | 32 | Register write data or bit mask |
| csr_rdata | output | 32 | Read data of the selected register |
| csr_fault | output | 1 | Write attempted on a read-only register |
| ext_pend_flag | output | 1 | Machine external-pending flag |
| low_idx | output | 5 | Lowest pending-and-enabled line |
| trap_req | output | 1 | Interrupt trap request |
| trap_addr | output | 32 | Trap target address |
| trap_cause | output | 6 | Cause code of the selected interrupt |

## Verification
Directed patterns come first, each on its own:
- A single line followed through its capture edge, which separates a correctly registered input from a combinational one.
- Two pending lines with the lower one disabled afterwards, which shows the enable filter and the lowest-index choice.
- All three vectoring settings applied to the same pending lines, which keeps the shared slot, the per-line slot and the unvectored base apart.
- Software, timer and external requests raised together, which fixes the priority order.

After these, a long run randomises:
- the lines, the enables and the base;
- the mode bit and the delay input;
- the register operations.

A behavioural model is compared with the outputs on every clock, so corner cases that no directed pattern aims at are still caught. These include writes to the unimplemented enable bits and faulted writes that land while the lines are changing.

// File: rtl/ext_irq_vectorer.sv
module ext_irq_vectorer #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 sw_irq,
  input  logic                 tmr_irq,
  input  logic                 glb_mie,
  input  logic                 en_ext,
  input  logic                 en_tmr,
  input  logic                 en_sw,
  input  logic [31:0]          vec_base,
  input  logic                 delay_entry,
  input  logic [1:0]           csr_sel,
  input  logic [1:0]           csr_op,
  input  logic [31:0]          csr_wdata,
  output logic [31:0]          csr_rdata,
  output logic                 csr_fault,
  output logic                 ext_pend_flag,
  output logic [4:0]           low_idx,
  output logic                 trap_req,
  output logic [31:0]          trap_addr,
  output logic [5:0]           trap_cause
);

  localparam logic [31:0] LINE_MASK   = 32'((64'd1 << NUM_LINES) - 64'd1);
  localparam logic [5:0]  CAUSE_SW    = 6'd3;
  localparam logic [5:0]  CAUSE_TMR   = 6'd7;
  localparam logic [5:0]  CAUSE_EXT   = 6'd11;
  localparam logic [5:0]  SLOT_OFFSET = 6'd16;

  localparam logic [1:0] SEL_ENA  = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_PEND = 2'd2;
  localparam logic [1:0] OP_IDLE  = 2'd0;
  localparam logic [1:0] OP_WR    = 2'd1;
  localparam logic [1:0] OP_SET   = 2'd2;
  localparam logic [1:0] OP_CLR   = 2'd3;

  logic [NUM_LINES-1:0] pend_q, ena_q;
  logic                 sw_q, tmr_q, mode_q;
  logic [31:0]          pend32, ena32, hits, ena_nx, mode_nx;
  logic                 wr_ena, wr_mode;

  function automatic logic [31:0] apply_op(input logic [1:0] op, input logic [31:0] prev,
                                           input logic [31:0] wd, input logic [31:0] mask);
    case (op)
      OP_WR:   return (wd & mask) | (prev & ~mask);
      OP_SET:  return prev | (wd & mask);
      OP_CLR:  return prev & ~(wd & mask);
      default: return prev;
    endcase
  endfunction

  assign pend32  = 32'(pend_q);
  assign ena32   = 32'(ena_q);
  assign hits    = pend32 & ena32;
  assign wr_ena  = (csr_op != OP_IDLE) && (csr_sel == SEL_ENA);
  assign wr_mode = (csr_op != OP_IDLE) && (csr_sel == SEL_MODE);
  assign ena_nx  = apply_op(csr_op, ena32, csr_wdata, LINE_MASK);
  assign mode_nx = apply_op(csr_op, {31'b0, mode_q}, csr_wdata, 32'h1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      sw_q   <= 1'b0;
      tmr_q  <= 1'b0;
      ena_q  <= LINE_MASK[NUM_LINES-1:0];
      mode_q <= 1'b0;
    end else begin
      pend_q <= irq_lines;
      sw_q   <= sw_irq;
      tmr_q  <= tmr_irq;
      if (wr_ena)  ena_q  <= ena_nx[NUM_LINES-1:0];
      if (wr_mode) mode_q <= mode_nx[0];
    end
  end

  assign ext_pend_flag = |hits;

  always_comb begin
    low_idx = 5'd0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (hits[i]) low_idx = 5'(i);
  end

  logic sw_act, tmr_act, ext_shared, ext_slot, any_act;
  assign sw_act     = glb_mie && en_sw && sw_q;
  assign tmr_act    = glb_mie && en_tmr && tmr_q;
  assign ext_shared = glb_mie && en_ext && ext_pend_flag && !mode_q;
  assign ext_slot   = glb_mie && en_ext && ext_pend_flag && mode_q;
  assign any_act    = sw_act || tmr_act || ext_shared || ext_slot;

  assign trap_cause = sw_act     ? CAUSE_SW :
                      tmr_act    ? CAUSE_TMR :
                      ext_shared ? CAUSE_EXT :
                      ext_slot   ? SLOT_OFFSET + {1'b0, low_idx} : 6'd0;
  assign trap_req   = any_act && !delay_entry;
  assign trap_addr  = {vec_base[31:2], 2'b00} +
                      (vec_base[0] ? {24'b0, trap_cause, 2'b00} : 32'd0);

  always_comb begin
    case (csr_sel)
      SEL_ENA:  csr_rdata = ena32;
      SEL_MODE: csr_rdata = {31'b0, mode_q};
      SEL_PEND: csr_rdata = pend32;
      default:  csr_rdata = {27'b0, low_idx};
    endcase
  end
  assign csr_fault = (csr_op != OP_IDLE) && csr_sel[1];

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel == SEL_ENA) |-> ((csr_rdata & ~LINE_MASK) == 32'd0)); // R1
  AST_FLAG_HAS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pend_flag |-> (pend32[low_idx] && ena32[low_idx])); // R4
  AST_TRAP_NEEDS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> glb_mie); // R5
  AST_SLOT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_cause >= SLOT_OFFSET) |-> mode_q); // R8
  AST_ENA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_op == OP_WR && csr_sel == SEL_ENA) |=> (ena32 == ($past(csr_wdata) & LINE_MASK))); // R11
  AST_DELAY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    delay_entry |-> !trap_req); // R13

endmodule

// File: tb/test_ext_irq_vectorer.sv
module test_ext_irq_vectorer;
  localparam int N = 20;
  localparam logic [31:0] M = (32'd1 << N) - 32'd1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_lines = '0;
  logic sw_irq = 0, tmr_irq = 0, glb_mie = 0, en_ext = 0, en_tmr = 0, en_sw = 0, delay_entry = 0;
  logic [31:0] vec_base = 32'd0, csr_wdata = 32'd0;
  logic [1:0] csr_sel = 2'd0, csr_op = 2'd0;
  logic [31:0] csr_rdata, trap_addr;
  logic csr_fault, ext_pend_flag, trap_req;
  logic [4:0] low_idx;
  logic [5:0] trap_cause;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [31:0] m_pend, m_ena;
  bit m_sw, m_tmr, m_mode;

  ext_irq_vectorer #(.NUM_LINES(N)) i_ext_irq_vectorer (
    .clk, .rst_n, .irq_lines, .sw_irq, .tmr_irq, .glb_mie, .en_ext, .en_tmr, .en_sw,
    .vec_base, .delay_entry, .csr_sel, .csr_op, .csr_wdata, .csr_rdata, .csr_fault,
    .ext_pend_flag, .low_idx, .trap_req, .trap_addr, .trap_cause);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] hits, e_cause, e_addr, e_rd;
    int e_idx;
    bit e_flag, e_act;
    string atag;
    hits = m_pend & m_ena;
    e_flag = (hits != 0);
    e_idx = 0;
    for (int i = N - 1; i >= 0; i--) if (hits[i]) e_idx = i;
    e_act = 1;
    if (glb_mie && en_sw && m_sw) e_cause = 3;
    else if (glb_mie && en_tmr && m_tmr) e_cause = 7;
    else if (glb_mie && en_ext && e_flag) e_cause = m_mode ? 16 + e_idx : 11;
    else begin e_cause = 0; e_act = 0; end
    e_addr = (vec_base & ~32'd3) + (vec_base[0] ? e_cause * 4 : 0);
    case (csr_sel)
      2'd0: e_rd = m_ena;
      2'd1: e_rd = {31'b0, m_mode};
      2'd2: e_rd = m_pend;
      default: e_rd = e_idx;
    endcase
    atag = !vec_base[0] ? "R6" : (e_cause == 3 || e_cause == 7) ? "R9" : m_mode ? "R8" : "R7";
    chk("R3 flag", ext_pend_flag, e_flag);
    chk("R4 index", low_idx, e_idx);
    chk("R5 trap_req", trap_req, e_act && !delay_entry);
    chk({atag, " cause"}, trap_cause, e_cause);
    chk({atag, " addr"}, trap_addr, e_addr);
    chk("R11 rdata", csr_rdata, e_rd);
    chk("R12 fault", csr_fault, csr_op != 0 && csr_sel[1]);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_ena = M; m_sw = 0; m_tmr = 0; m_mode = 0;
    end else begin
      m_pend = 32'(irq_lines); m_sw = sw_irq; m_tmr = tmr_irq;
      if (csr_op != 0 && csr_sel == 2'd0)
        case (csr_op)
          2'd1: m_ena = csr_wdata & M;
          2'd2: m_ena = m_ena | (csr_wdata & M);
          default: m_ena = m_ena & ~(csr_wdata & M);
        endcase
      if (csr_op != 0 && csr_sel == 2'd1)
        case (csr_op)
          2'd1: m_mode = csr_wdata[0];
          2'd2: m_mode = m_mode | csr_wdata[0];
          default: m_mode = m_mode & ~csr_wdata[0];
        endcase
    end
    #2;
    if (!done) compare_all();
  end

  task automatic after_edge();
    @(posedge clk); #3;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    csr_sel = 0; #1 chk("R10 enable reset", csr_rdata, M);
    csr_sel = 1; #1 chk("R10 mode reset", csr_rdata, 0);

    @(negedge clk); irq_lines = N'(1 << 5); csr_sel = 2;
    #1 chk("R2 not yet captured", csr_rdata, 0);
    after_edge(); chk("R2 captured", csr_rdata, 32'd1 << 5);

    @(negedge clk); irq_lines = '1;
    after_edge(); chk("R1 pending width", csr_rdata, M);
    @(negedge clk); csr_sel = 0; csr_op = 1; csr_wdata = 32'hffff_ffff;
    after_edge(); chk("R1 enable width", csr_rdata, M);
    @(negedge clk); csr_op = 0;

    @(negedge clk); irq_lines = N'((1 << 7) | (1 << 12)); glb_mie = 1; en_ext = 1;
    vec_base = 32'h1000_0001;
    after_edge(); chk("R7 cause", trap_cause, 11); chk("R7 addr", trap_addr, 32'h1000_002c);
    @(negedge clk); csr_sel = 1; csr_op = 1; csr_wdata = 32'hffff_ffff;
    after_edge(); chk("R11 mode bit only", csr_rdata, 1);
    @(negedge clk); csr_op = 0;
    #1 chk("R8 cause", trap_cause, 23); chk("R8 addr", trap_addr, 32'h1000_005c);
    @(negedge clk); csr_sel = 0; csr_op = 3; csr_wdata = 32'd1 << 7;
    after_edge(); chk("R4 lowest after clear", low_idx, 12);
    chk("R8 addr idx12", trap_addr, 32'h1000_0070);
    @(negedge clk); csr_op = 0; vec_base = 32'h1000_0002;
    #1 chk("R6 addr", trap_addr, 32'h1000_0000);

    @(negedge clk); vec_base = 32'h1000_0001; sw_irq = 1; tmr_irq = 1; en_sw = 1; en_tmr = 1;
    after_edge(); chk("R9 sw first", trap_cause, 3); chk("R9 sw addr", trap_addr, 32'h1000_000c);
    @(negedge clk); sw_irq = 0;
    after_edge(); chk("R9 timer next", trap_cause, 7);
    @(negedge clk); tmr_irq = 0;

    @(negedge clk); delay_entry = 1;
    #1 chk("R13 held off", trap_req, 0); chk("R13 index kept", low_idx, 12);
    @(negedge clk); delay_entry = 0;
    #1 chk("R13 released", trap_req, 1);
    @(negedge clk); glb_mie = 0;
    #1 chk("R5 no global", trap_req, 0);
    @(negedge clk); glb_mie = 1; en_ext = 0;
    #1 chk("R5 no ext enable", trap_req, 0);
    @(negedge clk); en_ext = 1;

    @(negedge clk); csr_sel = 2; csr_op = 1; csr_wdata = 32'd0;
    #1 chk("R12 pending fault", csr_fault, 1);
    after_edge(); chk("R12 pending unchanged", csr_rdata, (32'd1 << 7) | (32'd1 << 12));
    @(negedge clk); csr_sel = 3; csr_op = 2; csr_wdata = 32'h1f;
    #1 chk("R12 index fault", csr_fault, 1);
    after_edge(); chk("R12 index unchanged", csr_rdata, 12);
    @(negedge clk); csr_op = 0;

    repeat (3000) begin
      @(negedge clk);
      irq_lines = N'($urandom & $urandom);
      sw_irq = ($urandom % 4) == 0; tmr_irq = ($urandom % 4) == 0;
      glb_mie = ($urandom % 8) != 0; en_ext = ($urandom % 4) != 0;
      en_sw = $urandom % 2; en_tmr = $urandom % 2;
      delay_entry = ($urandom % 6) == 0;
      vec_base = $urandom;
      csr_sel = 2'($urandom);
      csr_op = (($urandom % 3) == 0) ? 2'($urandom) : 2'd0;
      csr_wdata = $urandom;
    end
    @(negedge clk); csr_op = 0;
    after_edge();
    finish_run();
  end
endmodule